// File: doc/BRIEF.md
# Retention-Aware Prefetch Tuning Controller

This controller tunes a cache whose cells hold data only for a limited time. It chooses two settings. The first is a retention setting, taken from a small indexed set where index 0 is the shortest retention and the top index is the longest. The second is a prefetch distance.

A tuning run starts with a start pulse. The controller then steps through the retention settings, one measurement window per setting, with the prefetch distance held at 1. A window lasts a fixed number of retired instructions. During each window the controller counts prefetched line fills and prefetched lines that expired without being used. From these two counts it works out how many unused lines expired per fill. The sweep begins at the longest setting and moves toward shorter ones. It stops at the first setting whose ratio is too high, and it keeps the setting measured just before that one.

A bank of comparators then turns the ratio measured at the kept setting into a distance. The distance is a power of two, and a lower ratio gives a larger distance. While a sweep runs, the cache is told which setting to use through the apply outputs. Once the sweep ends, the new selection appears on the select outputs and a done flag is raised.

Top module: `retention_prefetch_tuner`

## Requirements
- R1: After reset, selRet is NUM_RET-1 (the longest retention), selDist is 1 and tuneDone is 0.
- R2: A start pulse clears tuneDone on the following cycle and restarts the sweep at index NUM_RET-1. This also applies when a start arrives in the middle of a sweep.
- R3: While a sweep runs, applyRet shows the setting under trial and applyDist is 1. The trial index starts at NUM_RET-1 and drops by one after each window that passes.
- R4: A window closes on its WINDOW_LEN-th retire strobe. Fill and expiry strobes count only while the window is open. Strobes that arrive after the close, in the cycle before the next window opens, have no effect on the result.
- R5: A window fails when expired × 2^THR_SHIFT is greater than THRESHOLD × fills. Equality passes. A window with zero fills passes.
- R6: The sweep stops at the first failing window, and the selection becomes the index one above the failing trial. If every window passes, index 0 is selected. If the first window (the longest setting) fails, NUM_RET-1 is selected.
- R7: The selected distance is 2^j, where j is the largest value from 0 to DIST_LOG for which expired × 2^(THR_SHIFT+j) ≤ THRESHOLD × fills. The counts used are those of the window measured at the selected index. Zero fills give 2^DIST_LOG. A failing longest window gives a distance of 1.
- R8: The fill and expiry counters stop at 2^CNT_W-1 rather than wrapping. Both counters are cleared when each window opens.
- R9: selRet and selDist change only in the cycle where tuneDone rises, which is the cycle after the final window closes. tuneDone stays high until the next start.
- R10: When no sweep is running, applyRet equals selRet and applyDist equals selDist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that starts a tuning run |
| retire | input | 1 | One instruction retired this cycle |
| pfFill | input | 1 | A prefetched line was filled this cycle |
| pfExpired | input | 1 | A prefetched line expired without being used this cycle |
| applyRet | output | IDX_W | Retention index the cache should use now |
| applyDist | output | DIST_LOG+1 | Prefetch distance the cache should use now |
| selRet | output | IDX_W | Retention index chosen by the last completed run |
| selDist | output | DIST_LOG+1 | Prefetch distance chosen by the last completed run |
| tuneDone | output | 1 | The last run has finished |

## Verification
The properties assume three things about the inputs. Each event strobe is a single-cycle flag. Start is a one-cycle pulse. The retire stream eventually completes every window.

The stimulus keeps to these assumptions in two ways. It drives fills and expiries in a burst before the retire strobes, with each strobe held for at most one cycle. It then sends exactly WINDOW_LEN retires with random gaps between them, so every window closes.

One cycle after each close, the stimulus drives an expiry strobe. At that point the window is shut but the next one has not yet opened, so this strobe must leave the result unchanged. The random ratios are drawn on both sides of the threshold. Directed runs cover equality with the threshold, zero fills, counter saturation and a restart in the middle of a window.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  // strobes from the sequencer to the window datapath
  typedef struct packed {
    logic clearWin;  // open a fresh window, counters to zero
    logic stop;      // close measurement, no further windows
  } winCtl_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } seqState_t;
endpackage

// File: rtl/rpt_window_counters.sv
module rpt_window_counters
  import rpt_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int WINDOW_LEN = 10_000_000,
  parameter int THR_SHIFT  = 8,
  parameter int THRESHOLD  = 26,
  parameter int DIST_LOG   = 3,
  parameter int LVL_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  winCtl_t          ctl,
  input  logic             retire,
  input  logic             pfFill,
  input  logic             pfExpired,
  output logic             winDone,
  output logic             windowPass,
  output logic [LVL_W-1:0] distLevel
);
  localparam int ICNT_W = $clog2(WINDOW_LEN + 1);
  localparam int THR_W  = $clog2(THRESHOLD + 1);
  localparam int CMP_W  = CNT_W + THR_W + THR_SHIFT + DIST_LOG + 1;
  localparam logic [ICNT_W-1:0] LEN_V   = ICNT_W'(WINDOW_LEN);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic              active;
  logic [ICNT_W-1:0] instCnt;
  logic              winOpen;
  logic [1:0]        evIn;
  logic [CNT_W-1:0]  evCnt [2];

  assign winOpen = active && (instCnt != LEN_V);
  assign winDone = active && (instCnt == LEN_V);
  assign evIn    = {pfExpired, pfFill};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      instCnt <= '0;
    end else if (ctl.clearWin) begin
      active  <= 1'b1;
      instCnt <= '0;
    end else begin
      if (ctl.stop) active <= 1'b0;
      if (winOpen && retire) instCnt <= instCnt + 1'b1;
    end
  end

  // saturating event counters: index 0 fills, index 1 expired-unused
  for (genvar e = 0; e < 2; e++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        evCnt[e] <= '0;
      else if (ctl.clearWin)
        evCnt[e] <= '0;
      else if (winOpen && evIn[e] && evCnt[e] != CNT_MAX)
        evCnt[e] <= evCnt[e] + 1'b1;
    end
  end

  // ratio bands compared by shifting, no divider
  logic [CMP_W-1:0]  thrTimesFill;
  logic [DIST_LOG:0] levelOk;

  assign thrTimesFill = CMP_W'(THRESHOLD) * CMP_W'(evCnt[0]);

  for (genvar j = 0; j <= DIST_LOG; j++) begin : g_lvl
    assign levelOk[j] = (evCnt[0] == '0) ||
                        ((CMP_W'(evCnt[1]) << (THR_SHIFT + j)) <= thrTimesFill);
  end

  assign windowPass = levelOk[0];

  always_comb begin
    distLevel = '0;
    for (int j = 1; j <= DIST_LOG; j++)
      if (levelOk[j]) distLevel = LVL_W'(j);
  end
endmodule

// File: rtl/rpt_sequencer.sv
module rpt_sequencer
  import rpt_pkg::*;
#(
  parameter int NUM_RET = 4,
  parameter int IDX_W   = 2,
  parameter int LVL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             winDone,
  input  logic             windowPass,
  input  logic [LVL_W-1:0] distLevel,
  output winCtl_t          ctl,
  output logic             busy,
  output logic [IDX_W-1:0] trialIdx,
  output logic [IDX_W-1:0] selRetIdx,
  output logic [LVL_W-1:0] selLvl,
  output logic             tuneDone
);
  localparam logic [IDX_W-1:0] LONGEST = IDX_W'(NUM_RET - 1);

  seqState_t        state;
  logic [LVL_W-1:0] prevLvl;
  logic             judge, finish, advance;

  assign busy    = (state == ST_SEARCH);
  assign judge   = busy && winDone && !start;
  assign finish  = judge && (!windowPass || trialIdx == '0);
  assign advance = judge && !finish;

  assign ctl.clearWin = start || advance;
  assign ctl.stop     = finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      trialIdx  <= LONGEST;
      prevLvl   <= '0;
      selRetIdx <= LONGEST;
      selLvl    <= '0;
      tuneDone  <= 1'b0;
    end else if (start) begin
      state    <= ST_SEARCH;
      trialIdx <= LONGEST;
      tuneDone <= 1'b0;
    end else if (advance) begin
      trialIdx <= trialIdx - 1'b1;
      prevLvl  <= distLevel;
    end else if (finish) begin
      state    <= ST_IDLE;
      tuneDone <= 1'b1;
      if (!windowPass && trialIdx != LONGEST) begin
        selRetIdx <= trialIdx + 1'b1;
        selLvl    <= prevLvl;
      end else begin
        selRetIdx <= trialIdx;
        selLvl    <= distLevel;
      end
    end
  end
endmodule

// File: rtl/retention_prefetch_tuner.sv
module retention_prefetch_tuner
  import rpt_pkg::*;
#(
  parameter int NUM_RET    = 4,
  parameter int WINDOW_LEN = 10_000_000,
  parameter int CNT_W      = 24,
  parameter int THR_SHIFT  = 8,
  parameter int THRESHOLD  = 26,
  parameter int DIST_LOG   = 3,
  localparam int IDX_W     = (NUM_RET > 1) ? $clog2(NUM_RET) : 1,
  localparam int DIST_W    = DIST_LOG + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              retire,
  input  logic              pfFill,
  input  logic              pfExpired,
  output logic [IDX_W-1:0]  applyRet,
  output logic [DIST_W-1:0] applyDist,
  output logic [IDX_W-1:0]  selRet,
  output logic [DIST_W-1:0] selDist,
  output logic              tuneDone
);
  localparam int LVL_W = (DIST_LOG > 0) ? $clog2(DIST_LOG + 1) : 1;

  winCtl_t          winCtl;
  logic             winDone, windowPass, busy;
  logic [LVL_W-1:0] distLevel, selLvl;
  logic [IDX_W-1:0] trialIdx, selRetIdx;

  rpt_window_counters #(
    .CNT_W(CNT_W), .WINDOW_LEN(WINDOW_LEN), .THR_SHIFT(THR_SHIFT),
    .THRESHOLD(THRESHOLD), .DIST_LOG(DIST_LOG), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(winCtl), .retire(retire),
    .pfFill(pfFill), .pfExpired(pfExpired), .winDone(winDone),
    .windowPass(windowPass), .distLevel(distLevel)
  );

  rpt_sequencer #(
    .NUM_RET(NUM_RET), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .winDone(winDone),
    .windowPass(windowPass), .distLevel(distLevel), .ctl(winCtl),
    .busy(busy), .trialIdx(trialIdx), .selRetIdx(selRetIdx),
    .selLvl(selLvl), .tuneDone(tuneDone)
  );

  assign selRet    = selRetIdx;
  assign selDist   = DIST_W'(1) << selLvl;
  assign applyRet  = busy ? trialIdx : selRetIdx;
  assign applyDist = busy ? DIST_W'(1) : selDist;
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int IDX_W  = 2,
  parameter int DIST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              winDone,
  input logic              tuneDone,
  input logic [IDX_W-1:0]  applyRet,
  input logic [DIST_W-1:0] applyDist,
  input logic [IDX_W-1:0]  selRet,
  input logic [DIST_W-1:0] selDist
);
  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!tuneDone && busy));

  assert_unit_dist_search_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (applyDist == DIST_W'(1)));

  assert_trial_descends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start) |=> (!busy || applyRet <= $past(applyRet)));

  assert_window_closes_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (winDone && busy && !start) |=> !winDone);

  assert_dist_power_of_two_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(selDist) == 1) && ($countones(applyDist) == 1));

  assert_hold_selection_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(tuneDone) |-> ($stable(selRet) && $stable(selDist)));

  assert_done_means_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    tuneDone |-> !busy);
endmodule

bind retention_prefetch_tuner rpt_checker #(.IDX_W(IDX_W), .DIST_W(DIST_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .winDone(winDone),
  .tuneDone(tuneDone), .applyRet(applyRet), .applyDist(applyDist),
  .selRet(selRet), .selDist(selDist)
);

// File: tb/retention_prefetch_tuner_test.sv
module retention_prefetch_tuner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RET    = 4;
  localparam int WIN        = 20;
  localparam int CW         = 6;
  localparam int KSH        = 4;
  localparam int THR        = 4;
  localparam int DLOG       = 3;
  localparam int MAXC       = (1 << CW) - 1;
  localparam int LONG       = NUM_RET - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, retire = 1'b0, pfFill = 1'b0, pfExpired = 1'b0;
  logic [1:0] applyRet, selRet;
  logic [3:0] applyDist, selDist;
  logic tuneDone;

  int checks = 0;
  int errors = 0;
  int winFill [NUM_RET];
  int winExp  [NUM_RET];
  int heldRet = LONG;
  int heldDist = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  retention_prefetch_tuner #(
    .NUM_RET(NUM_RET), .WINDOW_LEN(WIN), .CNT_W(CW),
    .THR_SHIFT(KSH), .THRESHOLD(THR), .DIST_LOG(DLOG)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .retire(retire),
    .pfFill(pfFill), .pfExpired(pfExpired), .applyRet(applyRet),
    .applyDist(applyDist), .selRet(selRet), .selDist(selDist),
    .tuneDone(tuneDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int n);
    return (n > MAXC) ? MAXC : n;
  endfunction

  function automatic bit passM(input int f, input int e);
    int sf = sat(f);
    int se = sat(e);
    return (sf == 0) || ((se << KSH) <= THR * sf);
  endfunction

  function automatic int distM(input int f, input int e);
    int sf = sat(f);
    int se = sat(e);
    int lvl = 0;
    for (int j = 0; j <= DLOG; j++)
      if (sf == 0 || (se << (KSH + j)) <= THR * sf) lvl = j;
    return 1 << lvl;
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(tuneDone == 1'b0, "R2 done cleared", tuneDone, 0);
    check(applyRet == 2'(LONG), "R2 sweep from longest", applyRet, LONG);
  endtask

  task automatic runWindow(input int nF, input int nE, input int trial);
    int remF = nF;
    int remE = nE;
    int cnt = 0;
    check(applyRet == 2'(trial), "R3 trial index", applyRet, trial);
    check(applyDist == 4'd1, "R3 distance one in sweep", applyDist, 1);
    check(selRet == 2'(heldRet) && selDist == 4'(heldDist), "R9 held selection",
          selRet, heldRet);
    while (remF > 0 || remE > 0) begin
      @(negedge clk);
      pfFill    = (remF > 0) && ($urandom_range(0, 1) == 1);
      pfExpired = (remE > 0) && ($urandom_range(0, 1) == 1);
      if (pfFill) remF--;
      if (pfExpired) remE--;
    end
    while (cnt < WIN) begin
      @(negedge clk);
      pfFill = 1'b0;
      pfExpired = 1'b0;
      retire = ($urandom_range(0, 2) != 0);
      if (retire) begin
        cnt++;
        if (cnt == WIN - 1) begin
          @(negedge clk) retire = 1'b0;
          repeat (2) @(negedge clk);
          check(applyRet == 2'(trial) && !tuneDone, "R4 window still open",
                applyRet, trial);
        end
      end
    end
    @(negedge clk);
    retire = 1'b0;
    pfExpired = 1'b1;   // after close: must not count (R4)
    pfFill = 1'b1;
    @(negedge clk);
    pfExpired = 1'b0;
    pfFill = 1'b0;
  endtask

  task automatic runTune(input string tag);
    int idx = LONG;
    int prevD = 1;
    int expR = LONG;
    int expD = 1;
    pulseStart();
    forever begin
      runWindow(winFill[idx], winExp[idx], idx);
      if (!passM(winFill[idx], winExp[idx])) begin
        expR = (idx == LONG) ? LONG : idx + 1;
        expD = (idx == LONG) ? 1 : prevD;
        break;
      end
      if (idx == 0) begin
        expR = 0;
        expD = distM(winFill[0], winExp[0]);
        break;
      end
      prevD = distM(winFill[idx], winExp[idx]);
      idx--;
    end
    check(tuneDone == 1'b1, {"R9 done raised ", tag}, tuneDone, 1);
    check(selRet == 2'(expR), {"R6 retention ", tag}, selRet, expR);
    check(selDist == 4'(expD), {"R7 distance ", tag}, selDist, expD);
    check(applyRet == selRet && applyDist == selDist, {"R10 apply follows ", tag},
          applyRet, selRet);
    heldRet = expR;
    heldDist = expD;
  endtask

  task automatic setWin(input int i, input int f, input int e);
    winFill[i] = f;
    winExp[i] = e;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", checks, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(selRet == 2'(LONG), "R1 reset retention", selRet, LONG);
    check(selDist == 4'd1, "R1 reset distance", selDist, 1);
    check(tuneDone == 1'b0, "R1 reset done", tuneDone, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(applyRet == 2'(LONG) && applyDist == 4'd1, "R10 idle apply", applyRet, LONG);

    // zero fills pass with largest distance (R5, R7)
    for (int i = 0; i < NUM_RET; i++) setWin(i, 0, 5);
    runTune("zero fills");
    // longest fails (R6)
    setWin(3, 20, 10);
    runTune("longest fails");
    // fail at index 1, keep 2 with its distance
    setWin(3, 32, 0); setWin(2, 32, 2); setWin(1, 20, 10);
    runTune("stop mid");
    // equality passes, one above fails (R5)
    setWin(3, 16, 4); setWin(2, 16, 5);
    runTune("R5 equality");
    // fill counter saturation makes this fail (R8)
    setWin(3, 80, 16);
    runTune("R8 saturation");
    // clearing between windows (R8)
    setWin(3, 60, 0); setWin(2, 10, 2); setWin(1, 0, 0); setWin(0, 8, 3);
    runTune("R8 cleared");

    // restart mid-window (R2)
    setWin(3, 10, 0);
    pulseStart();
    runWindow(10, 0, 3);
    repeat (5) begin
      @(negedge clk) retire = 1'b1;
    end
    @(negedge clk) begin retire = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    check(tuneDone == 1'b0 && applyRet == 2'(LONG), "R2 restart mid window",
          applyRet, LONG);

    for (int it = 0; it < 25; it++) begin
      for (int i = 0; i < NUM_RET; i++) begin
        int f = $urandom_range(0, 40);
        setWin(i, f, $urandom_range(0, f / 3 + 1));
      end
      runTune("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule